// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This core encrypts a single 128-bit block with AES-128. A companion key-expansion unit supplies all eleven 128-bit round keys at once on a wide bus. One register holds the cipher state, and one round of logic is applied to it on each clock. A start strobe loads the plaintext with round key 0 already XORed in. The next ten clock edges each perform one round. After the tenth round the core raises a one-cycle done pulse, and the ciphertext then stays on the output until the next operation is accepted.

Each of the first nine rounds does four steps in this order: byte substitution, row rotation, column mixing, and the XOR with that round's key. The tenth round skips column mixing. The S-box is not stored as a table. It is computed in logic as the multiplicative inverse in GF(2^8) followed by the standard affine map.

Top module: `aes_enc_iter`

## Requirements
- R1: While reset is asserted and directly after it, `busy` and `done` are 0 and `cipherText` is all zeros.
- R2: A `start` sampled high while `busy` is 0 is accepted, and `busy` reads 1 in the following cycle.
- R3: `done` goes high exactly 10 clock edges after the edge that accepted `start`. It is high for one cycle, and `busy` is 0 in that same cycle.
- R4: When `done` is high, `cipherText` equals AES-128 of the accepted `plainText` under the given round keys. Byte 0 of any 128-bit value is bits [127:120], and state row r, column c holds byte r+4c. Round key k sits at `roundKeys[128*k +: 128]`, and key 0 is the cipher key itself.
- R5: A `start` sampled while `busy` is 1 is ignored. The running operation keeps its timing and its result.
- R6: From the `done` cycle until the next accepted `start`, `cipherText` holds its value and `done` stays 0 after its single pulse, even if `plainText` changes.
- R7: A `start` presented in the same cycle as `done` is accepted, and it begins a new encryption with the full R3 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin an encryption |
| plainText | input | 128 | Block to encrypt, sampled when start is accepted |
| roundKeys | input | 1408 | Eleven round keys, key k at bits [128k+127:128k] |
| busy | output | 1 | High while rounds are in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| cipherText | output | 128 | Result, held until the next accepted start |

## Verification
The core reads `roundKeys` on every round and samples `plainText` only at acceptance. The properties therefore take for granted that the key bus stays stable from acceptance until `done`. The stimulus loads the expanded keys before raising `start` and leaves them unchanged until the result has been checked. The round keys are produced by a key expansion written inside the bench, with its own S-box derived by searching for inverses. Plaintext is deliberately changed while the core is busy and after completion, to show that only the value present at acceptance has any effect.

// File: rtl/aes_pkg.sv
package aes_pkg;

  localparam int AES_ROUNDS = 10;
  localparam int BLOCK_BITS = 128;
  localparam int BYTE_BITS  = 8;
  localparam int NUM_BYTES  = BLOCK_BITS / BYTE_BITS;
  localparam int IDX_W      = $clog2(AES_ROUNDS + 1);

  // strobes from control to datapath
  typedef struct packed {
    logic             loadInit;   // capture plaintext ^ key 0
    logic             doRound;    // apply one round this edge
    logic             lastRound;  // bypass column mixing
    logic [IDX_W-1:0] roundIdx;   // which key to add
  } aesCtrlT;

  // multiply by x in GF(2^8), modulus x^8+x^4+x^3+x+1
  function automatic logic [7:0] gfDouble(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gfDouble(sh);
    end
    return acc;
  endfunction

  // x^254 is the inverse for nonzero x and 0 for x = 0
  function automatic logic [7:0] gfInv(input logic [7:0] x);
    logic [7:0] pw;
    logic [7:0] res;
    pw  = x;
    res = 8'h01;
    for (int i = 1; i < 8; i++) begin
      pw  = gfMul(pw, pw);
      res = gfMul(res, pw);
    end
    return res;
  endfunction

  function automatic logic [7:0] sboxCalc(input logic [7:0] x);
    logic [7:0] v;
    v = gfInv(x);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox (
  input  logic [7:0] byteIn,
  output logic [7:0] byteOut
);
  always_comb byteOut = aes_pkg::sboxCalc(byteIn);
endmodule

// File: rtl/aes_round_ctrl.sv
module aes_round_ctrl
  import aes_pkg::*;
#(
  parameter int NUM_ROUNDS = AES_ROUNDS
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output aesCtrlT ctrl,
  output logic    busy,
  output logic    done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ROUNDS);

  logic [IDX_W-1:0] roundCnt;
  logic             accept;

  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      roundCnt <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        roundCnt <= IDX_W'(1);
      end else if (busy) begin
        if (roundCnt == LAST_IDX) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          roundCnt <= roundCnt + IDX_W'(1);
        end
      end
    end
  end

  always_comb begin
    ctrl.loadInit  = accept;
    ctrl.doRound   = busy;
    ctrl.lastRound = busy && (roundCnt == LAST_IDX);
    ctrl.roundIdx  = accept ? '0 : roundCnt;
  end
endmodule

// File: rtl/aes_round_dp.sv
module aes_round_dp
  import aes_pkg::*;
#(
  parameter int NUM_ROUNDS = AES_ROUNDS
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  aesCtrlT                            ctrl,
  input  logic [BLOCK_BITS-1:0]              plainText,
  input  logic [(NUM_ROUNDS+1)*BLOCK_BITS-1:0] roundKeys,
  output logic [BLOCK_BITS-1:0]              stateOut
);
  logic [BLOCK_BITS-1:0] stateQ;
  logic [BLOCK_BITS-1:0] curKey;
  logic [7:0] subB [NUM_BYTES];
  logic [7:0] shfB [NUM_BYTES];
  logic [7:0] mixB [NUM_BYTES];
  logic [BLOCK_BITS-1:0] shfFlat;
  logic [BLOCK_BITS-1:0] mixFlat;
  logic [BLOCK_BITS-1:0] roundOut;

  assign curKey = roundKeys[int'(ctrl.roundIdx)*BLOCK_BITS +: BLOCK_BITS];

  // byte i occupies the i-th byte from the top
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_sub
    aes_sbox u_sbox (
      .byteIn (stateQ[BLOCK_BITS-1-BYTE_BITS*i -: BYTE_BITS]),
      .byteOut(subB[i])
    );
  end

  // row r rotates left by r columns
  for (genvar r = 0; r < 4; r++) begin : g_rowR
    for (genvar c = 0; c < 4; c++) begin : g_rowC
      assign shfB[r + 4*c] = subB[r + 4*((c + r) % 4)];
      assign shfFlat[BLOCK_BITS-1-BYTE_BITS*(r+4*c) -: BYTE_BITS] = shfB[r + 4*c];
    end
  end

  for (genvar c = 0; c < 4; c++) begin : g_mixC
    for (genvar k = 0; k < 4; k++) begin : g_mixK
      assign mixB[4*c + k] =
          gfDouble(shfB[4*c + k])
        ^ gfDouble(shfB[4*c + (k+1)%4]) ^ shfB[4*c + (k+1)%4]
        ^ shfB[4*c + (k+2)%4]
        ^ shfB[4*c + (k+3)%4];
      assign mixFlat[BLOCK_BITS-1-BYTE_BITS*(4*c+k) -: BYTE_BITS] = mixB[4*c + k];
    end
  end

  assign roundOut = (ctrl.lastRound ? shfFlat : mixFlat) ^ curKey;

  always_ff @(posedge clk) begin
    if (!rstN)             stateQ <= '0;
    else if (ctrl.loadInit) stateQ <= plainText ^ curKey;
    else if (ctrl.doRound)  stateQ <= roundOut;
  end

  assign stateOut = stateQ;
endmodule

// File: rtl/aes_enc_iter.sv
module aes_enc_iter
  import aes_pkg::*;
#(
  parameter int NUM_ROUNDS = AES_ROUNDS
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 start,
  input  logic [BLOCK_BITS-1:0]                plainText,
  input  logic [(NUM_ROUNDS+1)*BLOCK_BITS-1:0] roundKeys,
  output logic                                 busy,
  output logic                                 done,
  output logic [BLOCK_BITS-1:0]                cipherText
);
  aesCtrlT ctrl;

  aes_round_ctrl #(.NUM_ROUNDS(NUM_ROUNDS)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctrl (ctrl),
    .busy (busy),
    .done (done)
  );

  aes_round_dp #(.NUM_ROUNDS(NUM_ROUNDS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .plainText(plainText),
    .roundKeys(roundKeys),
    .stateOut (cipherText)
  );
endmodule

// File: rtl/aes_enc_iter_chk.sv
module aes_enc_iter_chk #(
  parameter int NUM_ROUNDS = aes_pkg::AES_ROUNDS
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [127:0] cipherText
);
  localparam int CW = $clog2(NUM_ROUNDS + 2);
  localparam logic [CW-1:0] LASTC = CW'(NUM_ROUNDS);

  logic [CW-1:0] edgesBusy;

  // edges seen with busy high since the last accepted start
  always_ff @(posedge clk) begin
    if (!rstN)              edgesBusy <= '0;
    else if (start && !busy) edgesBusy <= '0;
    else if (busy)          edgesBusy <= edgesBusy + CW'(1);
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);                                   // R2
  AST_DONE_AT_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (edgesBusy == LASTC) && !busy);                      // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                              // R3
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (edgesBusy < LASTC));                                // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(cipherText));                   // R6
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));                                        // R3
endmodule

bind aes_enc_iter aes_enc_iter_chk #(.NUM_ROUNDS(NUM_ROUNDS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .cipherText(cipherText)
);

// File: tb/aes_enc_iter_tb.sv
`timescale 1ns/1ps
module aes_enc_iter_tb;
  localparam int NR = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [127:0]  plainText = '0;
  logic [1407:0] roundKeys = '0;
  logic          busy;
  logic          done;
  logic [127:0]  cipherText;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  aes_enc_iter u_dut (
    .clk(clk), .rstN(rstN), .start(start), .plainText(plainText),
    .roundKeys(roundKeys), .busy(busy), .done(done), .cipherText(cipherText)
  );

  always #2 clk = ~clk;

  // {key, plaintext, expected ciphertext}
  localparam logic [383:0] KAT [3] = '{
    {128'h000102030405060708090a0b0c0d0e0f,
     128'h00112233445566778899aabbccddeeff,
     128'h69c4e0d86a7b0430d8cdb78070b4c55a},
    {128'h2b7e151628aed2a6abf7158809cf4f3c,
     128'h3243f6a8885a308d313198a2e0370734,
     128'h3925841d02dc09fbdc118597196a0b32},
    {128'h00000000000000000000000000000000,
     128'h00000000000000000000000000000000,
     128'h66e94bd4ef8a2c3b884cfa59ca342b2e}
  };

  logic [7:0] sTab [256];

  function automatic logic [7:0] tbMul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] prod;
    prod = '0;
    for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'h011b << (i - 8));
    return prod[7:0];
  endfunction

  function automatic logic [7:0] tbSbox(input logic [7:0] x);
    logic [7:0] inv;
    logic [7:0] o;
    inv = 8'h00;
    for (int y = 1; y < 256; y++) if (tbMul(x, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
    return o ^ 8'h63;
  endfunction

  function automatic logic [1407:0] tbExpand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    logic [1407:0] out;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sTab[t[31:24]], sTab[t[23:16]], sTab[t[15:8]], sTab[t[7:0]]};
        t = t ^ {rc, 24'h0};
        rc = tbMul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    out = '0;
    for (int k = 0; k < 11; k++)
      out[128*k +: 128] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
    return out;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // from a negedge: hold start for one edge
  task automatic pulseStart(input logic [127:0] pt);
    plainText = pt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // called right after the accepting edge; ends at the negedge after edge 10
  task automatic runRounds(input int injectAt, input logic [127:0] exp, input string req);
    bit early;
    early = 1'b0;
    check(busy === 1'b1, "R2", "busy after accept", 128'(busy), 128'd1);
    for (int k = 1; k <= NR; k++) begin
      if (k == injectAt) begin
        start = 1'b1;
        plainText = ~plainText;
      end
      @(negedge clk);
      start = 1'b0;
      if (k < NR && done !== 1'b0) early = 1'b1;
    end
    check(!early && done === 1'b1 && busy === 1'b0, "R3", "done on edge 10",
          {early, done, busy}, 128'b010);
    check(cipherText === exp, req, "ciphertext", cipherText, exp);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) sTab[i] = tbSbox(8'(i));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 1'b0 && done === 1'b0, "R1", "flags in reset", {busy, done}, 128'd0);
    check(cipherText === '0, "R1", "output in reset", cipherText, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && cipherText === '0, "R1", "after reset",
          cipherText, '0);

    // R4 known answers
    for (int v = 0; v < 3; v++) begin
      roundKeys = tbExpand(KAT[v][383:256]);
      pulseStart(KAT[v][255:128]);
      runRounds(0, KAT[v][127:0], "R4");
    end

    // R6 hold after done while plaintext moves
    begin
      logic [127:0] held;
      bit moved;
      held = cipherText;
      moved = 1'b0;
      for (int k = 0; k < 6; k++) begin
        plainText = {4{32'(k) ^ 32'hdeadbeef}};
        @(negedge clk);
        if (done !== 1'b0 || cipherText !== held) moved = 1'b1;
      end
      check(!moved, "R6", "held result", cipherText, held);
    end

    // R5 start while busy ignored
    roundKeys = tbExpand(KAT[1][383:256]);
    pulseStart(KAT[1][255:128]);
    runRounds(4, KAT[1][127:0], "R5");

    // R7 start in the done cycle
    roundKeys = tbExpand(KAT[0][383:256]);
    pulseStart(KAT[0][255:128]);
    runRounds(NR + 1, KAT[0][127:0], "R4");
    pulseStart(KAT[0][255:128]);
    runRounds(0, KAT[0][127:0], "R7");
    @(negedge clk);
    check(done === 1'b0, "R3", "done one cycle", 128'(done), 128'd0);

    // R7 back-to-back with a different key straight from done
    roundKeys = tbExpand(KAT[2][383:256]);
    pulseStart(KAT[2][255:128]);
    runRounds(0, KAT[2][127:0], "R4");
    roundKeys = tbExpand(KAT[1][383:256]);
    pulseStart(KAT[1][255:128]);
    runRounds(0, KAT[1][127:0], "R7");

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule